// File: doc/BRIEF.md
# Two-Way Instruction Cache Lookup

This block is the hit/miss core of a read-only instruction cache. A processor fetch port presents one byte address at a time and receives one 32-bit instruction word back. Two ways of lines are searched in parallel. Each line holds four words, and each line has its own tag and valid flag. A hit is answered from the data arrays. A miss sends one line request to a separate line-fill engine. That engine streams the four words of the line back in ascending order. The requested word is forwarded to the processor as it passes, and the line is written into the way chosen by a one-bit least-recently-used marker per set.

Three control inputs shape the behaviour. The enable input turns lookup on; while it is low, every fetch goes to the fill engine and nothing is stored. The freeze input keeps hits working but stops misses from allocating. The flush input is a one-cycle pulse that invalidates every line at once.

Hit latency depends on the request history. A hit costs two cycles in the general case. It costs one cycle when the request is accepted in the same cycle the previous response is delivered and its word address directly follows the previous one.

Top module: `icache_lookup`

## Requirements
- R1: The byte address splits into bits 1:0 (ignored, any value returns the same word), word select bits 3:2, set index bits 12:4 and tag bits 23:13 (default 24-bit address, 512 sets). A different tag in the same set never hits.
- R2: After reset, `req_ready` is 1 and `rsp_valid` and `fill_req` are 0. The cache is disabled and every line is invalid, so the first fetch after enabling misses.
- R3: A hit returns the stored word on `rsp_data` and raises no `fill_req`.
- R4: A hit that is not on the fast path answers two cycles late. If it is accepted at edge E, `rsp_valid` is high for one cycle after edge E+1, and `req_ready` is low between E and E+1.
- R5: A hit accepted while `rsp_valid` is high, whose word address equals the previous accepted word address plus one, answers one cycle after acceptance. This holds across line boundaries. A consecutive hit that is not sequential, or any hit after an idle cycle, takes the R4 path.
- R6: On a miss, `fill_req` is high for exactly one cycle, the cycle after acceptance, with `fill_addr` equal to the request address with bits 3:0 cleared. The engine returns words 0..3 on `fill_valid`/`fill_data`. `rsp_valid` is high in the cycle after the requested word arrives, and `req_ready` stays low until the cycle after word 3.
- R7: Each set has an LRU bit naming the way to replace; reset points it at way 0. A hit or a completed fill sets it to the other way, so of three tags in one set, the one least recently used is evicted.
- R8: While `cfg_enable` is 0, every fetch raises `fill_req` even if the line is present, returns the fetched word, and writes nothing into the arrays.
- R9: While `cfg_freeze` is 1, hits are served without `fill_req`, and misses still fetch all four words but allocate nothing, so a repeated miss misses again and resident lines keep their data.
- R10: A `cfg_flush` pulse invalidates every line by the next cycle. A flush during a line fill keeps that line from becoming valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Lookup and allocation enable |
| cfg_freeze | input | 1 | Serve hits, never allocate |
| cfg_flush | input | 1 | One-cycle pulse, invalidate all lines |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | ADDR_W (24) | Fetch byte address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data valid |
| rsp_data | output | 32 | Returned instruction word |
| fill_req | output | 1 | One-cycle line fetch request |
| fill_addr | output | ADDR_W (24) | Line-aligned byte address of the fetch |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | 32 | Fill word, in ascending word order |

## Verification
The bench builds the block with a 12-bit address and 4 sets. The tag then sits in bits 11:6, and the whole cache is eight lines. With that size, every word of every line in both ways can be filled and then read back as an isolated hit, with a different byte offset on each read. A sequential run crosses from one set into the next. Three tags contend for one set, so the LRU order is visible in the hit/miss pattern. The fill engine model stamps a changeable tag byte into each word it returns, which tells apart data kept from an earlier fill and data fetched anew under freeze, flush and disable.

// File: rtl/icl_pkg.sv
// Shared types for the two-way instruction cache lookup.
// Assumes: nothing beyond the types declared here.
package icl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // accepting requests
        ST_WAIT = 2'd1,   // second cycle of a slow hit
        ST_FILL = 2'd2    // streaming a line from the fill engine
    } icl_state_e;
endpackage

// File: rtl/icl_tag_store.sv
// Tag, valid and LRU state for two ways; parallel compare of one lookup.
// Assumes: touch and commit never target the same cycle; flush wins over commit.
module icl_tag_store #(
    parameter int SETS  = 512,
    parameter int TAG_W = 11,
    localparam int INDEX_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic               lk_way,
    output logic               lk_victim,
    input  logic               touch_en,
    input  logic [INDEX_W-1:0] touch_idx,
    input  logic               touch_way,
    input  logic               commit_en,
    input  logic [INDEX_W-1:0] commit_idx,
    input  logic               commit_way,
    input  logic [TAG_W-1:0]   commit_tag,
    input  logic               flush
);
    logic [TAG_W-1:0] tag_q [2][SETS];
    logic [SETS-1:0]  vld_q [2];
    logic [SETS-1:0]  lru_q;
    logic [1:0]       hit_vec;

    // Per-way compare of the stored tag against the lookup tag.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    end

    assign lk_hit    = |hit_vec;
    assign lk_way    = hit_vec[1];
    assign lk_victim = lru_q[lk_idx];

    // Tag write on a completed fill; tags need no reset.
    always_ff @(posedge clk) begin
        if (commit_en) tag_q[commit_way][commit_idx] <= commit_tag;
    end

    // Valid flags: cleared by reset or flush, set by a completed fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q[0] <= '0;
            vld_q[1] <= '0;
        end else if (commit_en) begin
            vld_q[commit_way][commit_idx] <= 1'b1;
        end
    end

    // LRU bit: points at the way not used most recently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (touch_en)  lru_q[touch_idx]  <= ~touch_way;
            if (commit_en) lru_q[commit_idx] <= ~commit_way;
        end
    end

    assert_one_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q[0] == '0 && vld_q[1] == '0));
endmodule

// File: rtl/icl_data_store.sv
// Two ways of line-wide data arrays, word-granular write, word read.
// Assumes: read and write ports are independent; no reset on contents.
module icl_data_store #(
    parameter int SETS   = 512,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int INDEX_W = $clog2(SETS),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int LINE_W  = WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rd_way,
    input  logic [INDEX_W-1:0] rd_idx,
    input  logic [WSEL_W-1:0]  rd_word,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic               wr_way,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [WSEL_W-1:0]  wr_word,
    input  logic [DATA_W-1:0]  wr_data
);
    logic [LINE_W-1:0] mem_q [2][SETS];

    // Combinational word read from the selected way.
    assign rd_data = mem_q[rd_way][rd_idx][rd_word*DATA_W +: DATA_W];

    // One word written per fill beat.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_way][wr_idx][wr_word*DATA_W +: DATA_W] <= wr_data;
    end
endmodule

// File: rtl/icl_sequencer.sv
// Request sequencing: hit latency choice, miss handling, fill streaming.
// Assumes: fill words arrive in ascending order, at most one per cycle,
// and only after fill_req; lookup results describe req_addr this cycle.
module icl_sequencer
    import icl_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SETS   = 512,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int INDEX_W = $clog2(SETS),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int OFF_W   = WSEL_W + 2,
    localparam int TAG_W   = ADDR_W - OFF_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_freeze,
    input  logic               cfg_flush,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               fill_req,
    output logic [ADDR_W-1:0]  fill_addr,
    input  logic               fill_valid,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               lk_hit,
    input  logic               lk_way,
    input  logic               lk_victim,
    input  logic [DATA_W-1:0]  lk_word_data,
    output logic               touch_en,
    output logic               touch_way,
    output logic [INDEX_W-1:0] touch_idx,
    output logic               commit_en,
    output logic               commit_way,
    output logic [INDEX_W-1:0] commit_idx,
    output logic [TAG_W-1:0]   commit_tag,
    output logic               wr_en,
    output logic               wr_way,
    output logic [INDEX_W-1:0] wr_idx,
    output logic [WSEL_W-1:0]  wr_word,
    output logic [DATA_W-1:0]  wr_data
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    icl_state_e         state_q;
    logic               rsp_valid_q;
    logic [DATA_W-1:0]  rsp_data_q;
    logic               fill_req_q;
    logic [ADDR_W-1:0]  fill_addr_q;
    logic               alloc_q;
    logic               victim_q;
    logic [WSEL_W-1:0]  miss_word_q;
    logic [INDEX_W-1:0] miss_idx_q;
    logic [TAG_W-1:0]   miss_tag_q;
    logic [WSEL_W-1:0]  cnt_q;
    logic [ADDR_W-1:0]  prev_addr_q;

    logic               fire;
    logic               use_hit;
    logic               seq_ok;
    logic               last_beat;
    logic [WSEL_W-1:0]  cur_word;
    logic [INDEX_W-1:0] cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [ADDR_W-1:0]  line_addr;

    // Address fields and request qualification.
    always_comb begin
        cur_word  = req_addr[OFF_W-1:2];
        cur_idx   = req_addr[OFF_W+INDEX_W-1:OFF_W];
        cur_tag   = req_addr[ADDR_W-1:OFF_W+INDEX_W];
        line_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        req_ready = (state_q == ST_IDLE);
        fire      = req_valid && req_ready;
        use_hit   = cfg_enable && !cfg_flush && lk_hit;
        seq_ok    = rsp_valid_q && ((req_addr >> 2) == ((prev_addr_q >> 2) + 1'b1));
        last_beat = fill_valid && (cnt_q == LAST_WORD);
    end

    // Store-side controls: LRU touch on hit, word write and commit on fill.
    always_comb begin
        touch_en   = fire && use_hit;
        touch_way  = lk_way;
        touch_idx  = cur_idx;
        wr_en      = (state_q == ST_FILL) && fill_valid && alloc_q;
        wr_way     = victim_q;
        wr_idx     = miss_idx_q;
        wr_word    = cnt_q;
        wr_data    = fill_data;
        commit_en  = (state_q == ST_FILL) && last_beat && alloc_q && !cfg_flush;
        commit_way = victim_q;
        commit_idx = miss_idx_q;
        commit_tag = miss_tag_q;
    end

    // Main sequencing state and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            fill_req_q  <= 1'b0;
            fill_addr_q <= '0;
            alloc_q     <= 1'b0;
            victim_q    <= 1'b0;
            miss_word_q <= '0;
            miss_idx_q  <= '0;
            miss_tag_q  <= '0;
            cnt_q       <= '0;
            prev_addr_q <= '0;
        end else begin
            fill_req_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    rsp_valid_q <= 1'b0;
                    if (fire) begin
                        prev_addr_q <= req_addr;
                        if (use_hit) begin
                            rsp_data_q <= lk_word_data;
                            if (seq_ok) rsp_valid_q <= 1'b1;
                            else        state_q     <= ST_WAIT;
                        end else begin
                            state_q     <= ST_FILL;
                            fill_req_q  <= 1'b1;
                            fill_addr_q <= line_addr;
                            alloc_q     <= cfg_enable && !cfg_freeze;
                            victim_q    <= lk_victim;
                            miss_word_q <= cur_word;
                            miss_idx_q  <= cur_idx;
                            miss_tag_q  <= cur_tag;
                            cnt_q       <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    rsp_valid_q <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                ST_FILL: begin
                    rsp_valid_q <= 1'b0;
                    if (cfg_flush) alloc_q <= 1'b0;
                    if (fill_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == miss_word_q) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= fill_data;
                        end
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign fill_req  = fill_req_q;
    assign fill_addr = fill_addr_q;

    assert_fill_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req);
    assert_slow_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> (rsp_valid && req_ready));
    assert_fast_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && use_hit && seq_ok) |=> (rsp_valid && req_ready));
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg_enable) |=> (fill_req && !req_ready));
endmodule

// File: rtl/icache_lookup.sv
// Top of the two-way instruction cache lookup: splits the fetch address,
// wires the tag store, data store and sequencer.
// Assumes: a single outstanding fetch; a fill engine that answers fill_req.
module icache_lookup #(
    parameter int ADDR_W = 24,
    parameter int SETS   = 512,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int INDEX_W = $clog2(SETS),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int OFF_W   = WSEL_W + 2,
    localparam int TAG_W   = ADDR_W - OFF_W - INDEX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_freeze,
    input  logic              cfg_flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    logic               lk_hit, lk_way, lk_victim;
    logic [DATA_W-1:0]  lk_word_data;
    logic               touch_en, touch_way;
    logic [INDEX_W-1:0] touch_idx;
    logic               commit_en, commit_way;
    logic [INDEX_W-1:0] commit_idx;
    logic [TAG_W-1:0]   commit_tag;
    logic               wr_en, wr_way;
    logic [INDEX_W-1:0] wr_idx;
    logic [WSEL_W-1:0]  wr_word;
    logic [DATA_W-1:0]  wr_data;

    icl_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (req_addr[OFF_W+INDEX_W-1:OFF_W]),
        .lk_tag     (req_addr[ADDR_W-1:OFF_W+INDEX_W]),
        .lk_hit     (lk_hit),
        .lk_way     (lk_way),
        .lk_victim  (lk_victim),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .touch_way  (touch_way),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .commit_way (commit_way),
        .commit_tag (commit_tag),
        .flush      (cfg_flush)
    );

    icl_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_way  (lk_way),
        .rd_idx  (req_addr[OFF_W+INDEX_W-1:OFF_W]),
        .rd_word (req_addr[OFF_W-1:2]),
        .rd_data (lk_word_data),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .wr_data (wr_data)
    );

    icl_sequencer #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_freeze   (cfg_freeze),
        .cfg_flush    (cfg_flush),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .fill_req     (fill_req),
        .fill_addr    (fill_addr),
        .fill_valid   (fill_valid),
        .fill_data    (fill_data),
        .lk_hit       (lk_hit),
        .lk_way       (lk_way),
        .lk_victim    (lk_victim),
        .lk_word_data (lk_word_data),
        .touch_en     (touch_en),
        .touch_way    (touch_way),
        .touch_idx    (touch_idx),
        .commit_en    (commit_en),
        .commit_way   (commit_way),
        .commit_idx   (commit_idx),
        .commit_tag   (commit_tag),
        .wr_en        (wr_en),
        .wr_way       (wr_way),
        .wr_idx       (wr_idx),
        .wr_word      (wr_word),
        .wr_data      (wr_data)
    );
endmodule

// File: tb/icache_lookup_test.sv
`timescale 1ns/1ps
module icache_lookup_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0, cfg_freeze = 1'b0, cfg_flush = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_valid, fill_req;
    logic [31:0]   rsp_data;
    logic [AW-1:0] fill_addr;
    logic          fill_valid = 1'b0;
    logic [31:0]   fill_data = '0;
    logic [7:0]    salt = 8'h00;
    int            checks = 0, fails = 0, fill_count = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    icache_lookup #(.ADDR_W(AW), .SETS(4), .WORDS(4), .DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
        .cfg_flush(cfg_flush), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_data(fill_data)
    );

    function automatic logic [AW-1:0] mk(input int tag, input int set, input int word, input int bsel);
        return AW'((tag << 6) | (set << 4) | (word << 2) | bsel);
    endfunction

    function automatic logic [31:0] fdata(input logic [7:0] s, input logic [AW-1:0] a);
        return {s, 12'h000, a & 12'hFFC};
    endfunction

    // Fill engine model: one idle cycle, then four words in ascending order.
    always @(posedge clk) if (fill_req) fill_count <= fill_count + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                logic [AW-1:0] line;
                line = fill_addr;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    fill_valid = 1'b1;
                    fill_data  = fdata(salt, line + AW'(4 * k));
                end
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_req(input logic [AW-1:0] a);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic await_rsp(output int lat, output logic [31:0] d);
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
    endtask

    // One fetch with expected miss flag, latency (-1 skips) and data salt.
    task automatic fetch(input string req, input logic [AW-1:0] a, input bit iso,
                         input bit exp_miss, input int exp_lat, input logic [7:0] exp_salt);
        int lat;
        int f0;
        logic [31:0] d;
        if (iso) @(negedge clk);
        f0 = fill_count;
        start_req(a);
        await_rsp(lat, d);
        chk({req, " miss"}, 32'(fill_count != f0), 32'(exp_miss));
        if (exp_lat >= 0) chk({req, " latency"}, 32'(lat), 32'(exp_lat));
        chk({req, " data"}, d, fdata(exp_salt, a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 ready", 32'(req_ready), 32'd1);
        chk("R2 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R2 fill_req", 32'(fill_req), 32'd0);

        // R8 disabled fetch goes to the fill port; R2 first enabled fetch misses
        fetch("R8 bypass", mk(1, 0, 2, 0), 1, 1, 5, 8'h00);
        cfg_enable = 1'b1;
        fetch("R2 cold miss", mk(1, 0, 2, 0), 1, 1, 5, 8'h00);

        // R6 fill every line of both ways, latency 3 + word position
        for (int s = 0; s < 4; s++)
            for (int t = 1; t <= 2; t++)
                if (!(s == 0 && t == 1))
                    fetch("R6 fill", mk(t, s, (s + t) % 4, 0), 1, 1, 3 + (s + t) % 4, 8'h00);

        // R3 R4 R1 every word as an isolated hit, varied byte offset
        for (int s = 0; s < 4; s++)
            for (int t = 1; t <= 2; t++)
                for (int w = 0; w < 4; w++)
                    fetch("R3 R4 R1 hit", mk(t, s, w, (w + s) % 4), 1, 0, 2, 8'h00);

        // R5 sequential back-to-back run across a line boundary
        fetch("R5 first", mk(1, 0, 0, 0), 1, 0, 2, 8'h00);
        for (int i = 1; i < 8; i++)
            fetch("R5 sequential", mk(1, 0, 0, 0) + AW'(4 * i), 0, 0, 1, 8'h00);
        fetch("R5 skip", mk(1, 1, 3, 0) + AW'(8), 0, 0, 2, 8'h00);
        fetch("R5 repeat", mk(2, 0, 1, 0), 0, 0, 2, 8'h00);
        fetch("R5 repeat same", mk(2, 0, 1, 0), 0, 0, 2, 8'h00);

        // R7 three tags contend for set 2
        fetch("R7 touch", mk(1, 2, 0, 0), 1, 0, 2, 8'h00);
        salt = 8'h01;
        fetch("R7 new tag", mk(3, 2, 1, 0), 1, 1, 4, 8'h01);
        fetch("R7 kept", mk(1, 2, 1, 0), 1, 0, 2, 8'h00);
        fetch("R7 evicted", mk(2, 2, 0, 0), 1, 1, 3, 8'h01);
        fetch("R7 evicted again", mk(3, 2, 0, 0), 1, 1, 3, 8'h01);
        fetch("R7 resident", mk(2, 2, 3, 0), 1, 0, 2, 8'h01);
        fetch("R7 lru victim", mk(1, 2, 0, 0), 1, 1, 3, 8'h01);
        // R1 a tag differing only in its top bit misses
        fetch("R1 tag bit", mk(33, 3, 0, 0), 1, 1, 3, 8'h01);

        // R9 freeze: hits served, misses never allocate
        salt = 8'h02;
        cfg_freeze = 1'b1;
        fetch("R9 frozen hit", mk(1, 0, 1, 0), 1, 0, 2, 8'h00);
        fetch("R9 frozen miss", mk(5, 0, 2, 0), 1, 1, 5, 8'h02);
        fetch("R9 miss again", mk(5, 0, 2, 0), 1, 1, 5, 8'h02);
        fetch("R9 kept way a", mk(1, 0, 3, 0), 1, 0, 2, 8'h00);
        fetch("R9 kept way b", mk(2, 0, 3, 0), 1, 0, 2, 8'h00);
        cfg_freeze = 1'b0;

        // R10 flush invalidates everything
        @(negedge clk);
        cfg_flush = 1'b1;
        @(negedge clk);
        cfg_flush = 1'b0;
        fetch("R10 after flush", mk(2, 0, 0, 0), 1, 1, 3, 8'h02);
        fetch("R10 refilled", mk(2, 0, 2, 0), 1, 0, 2, 8'h02);
        // R10 flush during a fill blocks that line
        begin
            int lat;
            logic [31:0] d;
            @(negedge clk);
            start_req(mk(1, 1, 2, 0));
            cfg_flush = 1'b1;
            @(negedge clk);
            cfg_flush = 1'b0;
            await_rsp(lat, d);
            chk("R10 fill data", d, fdata(8'h02, mk(1, 1, 2, 0)));
        end
        fetch("R10 line not kept", mk(1, 1, 0, 0), 1, 1, 3, 8'h02);
        fetch("R10 other flushed", mk(2, 0, 1, 0), 1, 1, 4, 8'h02);

        // R8 disabled fetch ignores a resident line and stores nothing
        salt = 8'h03;
        cfg_enable = 1'b0;
        fetch("R8 resident bypass", mk(1, 1, 1, 0), 1, 1, 4, 8'h03);
        cfg_enable = 1'b1;
        fetch("R8 no overwrite", mk(1, 1, 1, 0), 1, 0, 2, 8'h02);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule